// File: doc/BRIEF.md
# Multichannel PWM with Period-Boundary Buffered Updates

This block drives a set of independent pulse-width modulated outputs from one clock. Each channel owns a free-running counter and two pairs of registers for period and duty: a live pair that the counter compares against, and a pending pair that software writes. A new value written to the pending pair waits there. It moves into the live pair only when the channel finishes its current period. Because of this, a running waveform never changes shape partway through a period.

Software programs the block over a simple single-cycle register bus. A write strobe and a read strobe share one byte address. Read data comes back, registered, one cycle after the read strobe. Each channel's registers sit at a channel base plus the channel index times a fixed stride. A shared status register holds one bit per channel. A channel's bit is set whenever that channel starts a new period. Reading the status register returns all the bits and clears them in the same access. A single interrupt line is raised while any status bit is set whose matching bit in an interrupt mask register is also set.

Each channel also has an enable bit. The enable bits are set through one address and cleared through another. While a channel is disabled, its counter is held at zero and its output is held low. Its pending values are also loaded straight into the live pair, so the first period after enabling already uses them.

Top module: `pwm_buf_top`

## Requirements
- R1: Global addresses (byte addresses) are as follows:
  - 0x004: write ones to enable channels; a read returns the enable bits.
  - 0x008: write ones to disable channels; a read returns zero.
  - 0x010: interrupt mask, read and write.
  - 0x01C: status.
  - Channel i occupies 0x200 + i*0x20. Its offsets are: 0x00 live period (read only), 0x04 pending period, 0x08 live duty (read only), 0x0C pending duty.
  - Any other address reads as zero and ignores writes.
  - Read data appears on `bus_rdata` in the cycle after `bus_rd`, and is zero after a cycle with no read.
- R2: A write to a pending period or pending duty register of an enabled channel leaves that channel's live values and output unchanged until the end of the period in progress.
- R3: At the clock edge where an enabled channel's period ends, both the pending period and the pending duty move into the live registers on that same edge. The values moved are those held before that edge.
- R4: An enabled channel's counter counts 0, 1, … up to live period − 1, then returns to 0. A live period of 0 or 1 keeps the counter at 0. The output is registered: in each cycle it equals (counter < live duty) as evaluated in the previous cycle.
- R5: A live duty of 0 gives a constant low output. A live duty equal to or greater than the live period gives a constant high output.
- R6: A channel's status bit is set on the same edge where its counter returns to 0.
- R7: Reading address 0x01C returns all status bits and clears them. A bit that is being set on the edge of that read stays set.
- R8: `irq` is high in a cycle exactly when, in the previous cycle, (status AND mask) was nonzero.
- R9: Writing ones to 0x004 sets enable bits, and writing ones to 0x008 clears them. A disabled channel holds its counter at 0 and its output low, and it loads its pending values into its live registers on every edge.
- R10: After reset, every register, `pwm_out`, `irq` and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | NCH | Registered PWM outputs, one per channel |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with four channels and an 8-bit counter. This keeps the period values small, so many wraps fit into a short run. With periods of 10, 6, 5 and 1, status reads issued every seven cycles repeatedly land on the same edge as a channel's wrap, which exercises the set-during-clear case. The small counter also brings a period of 0 and a duty that exceeds the period into reach without long runs.

// File: rtl/pwm_buf_pkg.sv
package pwm_buf_pkg;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CH_STRIDE = 32;
  localparam int unsigned STRIDE_LG = $clog2(CH_STRIDE);

  localparam logic [ADDR_W-1:0] A_ENA   = 12'h004;
  localparam logic [ADDR_W-1:0] A_DIS   = 12'h008;
  localparam logic [ADDR_W-1:0] A_IMASK = 12'h010;
  localparam logic [ADDR_W-1:0] A_STAT  = 12'h01C;
  localparam logic [ADDR_W-1:0] CH_BASE = 12'h200;

  localparam logic [STRIDE_LG-1:0] O_PER_LIVE  = 5'h00;
  localparam logic [STRIDE_LG-1:0] O_PER_PEND  = 5'h04;
  localparam logic [STRIDE_LG-1:0] O_DUTY_LIVE = 5'h08;
  localparam logic [STRIDE_LG-1:0] O_DUTY_PEND = 5'h0C;
endpackage

// File: rtl/pwm_buf_channel.sv
module pwm_buf_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wr_per,
  input  logic             wr_duty,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] per_live,
  output logic [CNT_W-1:0] per_pend,
  output logic [CNT_W-1:0] duty_live,
  output logic [CNT_W-1:0] duty_pend,
  output logic             wrap,
  output logic             pwm_q
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_inc;
  logic             reload;

  // end of period: next count would reach the live period
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign wrap    = en && (cnt_inc >= {1'b0, per_live});
  assign reload  = !en || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_pend  <= '0;
      duty_pend <= '0;
    end else begin
      if (wr_per)  per_pend  <= wdata;
      if (wr_duty) duty_pend <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_live  <= '0;
      duty_live <= '0;
      cnt       <= '0;
    end else if (reload) begin
      per_live  <= per_pend;
      duty_live <= duty_pend;
      cnt       <= '0;
    end else begin
      cnt <= cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= en && (cnt < duty_live);
  end
endmodule

// File: rtl/pwm_buf_status.sv
module pwm_buf_status #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_vec,
  input  logic           clr,
  input  logic [NCH-1:0] mask,
  output logic [NCH-1:0] stat,
  output logic           irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat  <= '0;
      irq_q <= 1'b0;
    end else begin
      stat  <= (clr ? '0 : stat) | set_vec;
      irq_q <= |(stat & mask);
    end
  end
endmodule

// File: rtl/pwm_buf_top.sv
module pwm_buf_top
  import pwm_buf_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic              irq
);
  localparam int unsigned SPAN = NCH * CH_STRIDE;

  logic [NCH-1:0]            en_q;
  logic [NCH-1:0]            mask_q;
  logic [NCH-1:0]            stat_q;
  logic [NCH-1:0]            start_vec;
  logic [NCH-1:0][CNT_W-1:0] per_live_w, per_pend_w, duty_live_w, duty_pend_w;

  logic [ADDR_W-1:0]    ch_rel, ch_sel;
  logic [STRIDE_LG-1:0] ch_off;
  logic                 ch_hit;
  logic                 stat_rd;
  logic [DATA_W-1:0]    rd_mux;
  logic                 unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign ch_rel  = bus_addr - CH_BASE;
  assign ch_hit  = (bus_addr >= CH_BASE) && ({20'd0, ch_rel} < SPAN);
  assign ch_sel  = ch_rel >> STRIDE_LG;
  assign ch_off  = ch_rel[STRIDE_LG-1:0];
  assign stat_rd = bus_rd && (bus_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_ENA)   en_q   <= en_q | bus_wdata[NCH-1:0];
      if (bus_addr == A_DIS)   en_q   <= en_q & ~bus_wdata[NCH-1:0];
      if (bus_addr == A_IMASK) mask_q <= bus_wdata[NCH-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = bus_wr && ch_hit && (ch_sel == ADDR_W'(i));
    pwm_buf_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .en       (en_q[i]),
      .wr_per   (sel && (ch_off == O_PER_PEND)),
      .wr_duty  (sel && (ch_off == O_DUTY_PEND)),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .per_live (per_live_w[i]),
      .per_pend (per_pend_w[i]),
      .duty_live(duty_live_w[i]),
      .duty_pend(duty_pend_w[i]),
      .wrap     (start_vec[i]),
      .pwm_q    (pwm_out[i])
    );
  end

  pwm_buf_status #(.NCH(NCH)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .set_vec(start_vec),
    .clr    (stat_rd),
    .mask   (mask_q),
    .stat   (stat_q),
    .irq_q  (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_ENA)   rd_mux = DATA_W'(en_q);
    if (bus_addr == A_IMASK) rd_mux = DATA_W'(mask_q);
    if (bus_addr == A_STAT)  rd_mux = DATA_W'(stat_q);
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit && ch_sel == ADDR_W'(i)) begin
        case (ch_off)
          O_PER_LIVE:  rd_mux = DATA_W'(per_live_w[i]);
          O_PER_PEND:  rd_mux = DATA_W'(per_pend_w[i]);
          O_DUTY_LIVE: rd_mux = DATA_W'(duty_live_w[i]);
          O_DUTY_PEND: rd_mux = DATA_W'(duty_pend_w[i]);
          default:     rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_mux : '0;
  end
endmodule

// File: rtl/pwm_buf_checker.sv
module pwm_buf_checker
  import pwm_buf_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_rd,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [NCH-1:0]            en_q,
  input logic [NCH-1:0]            mask_q,
  input logic [NCH-1:0]            stat_q,
  input logic [NCH-1:0]            start_vec,
  input logic [NCH-1:0][CNT_W-1:0] duty_live_w,
  input logic [NCH-1:0]            pwm_out,
  input logic                      irq
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_off_low_R9: assert property (@(posedge clk) disable iff (rst)
      !en_q[i] |=> !pwm_out[i]);
    assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (rst)
      (en_q[i] && duty_live_w[i] == '0) |=> !pwm_out[i]);
    assert_duty_held_R2: assert property (@(posedge clk) disable iff (rst)
      (en_q[i] && !start_vec[i]) |=> $stable(duty_live_w[i]));
    assert_start_sets_R6: assert property (@(posedge clk) disable iff (rst)
      start_vec[i] |=> stat_q[i]);
  end

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STAT) |=> (stat_q == $past(start_vec)));
  assert_irq_high_R8: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q & mask_q)) |=> irq);
  assert_irq_low_R8: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_q & mask_q)) |=> !irq);
endmodule

bind pwm_buf_top pwm_buf_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .en_q       (en_q),
  .mask_q     (mask_q),
  .stat_q     (stat_q),
  .start_vec  (start_vec),
  .duty_live_w(duty_live_w),
  .pwm_out    (pwm_out),
  .irq        (irq)
);

// File: tb/pwm_buf_top_test.sv
module pwm_buf_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 4;
  localparam int CW   = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_buf_top #(.NCH(NCH), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  int vecs = 0, errs = 0;
  bit after_reset = 1'b0;

  // behavioural reference state
  int m_per[NCH], m_perp[NCH], m_duty[NCH], m_dutyp[NCH], m_cnt[NCH];
  bit m_en[NCH], m_mask[NCH], m_stat[NCH], m_pwm[NCH];
  bit m_irq;
  int m_rdata;
  string pwm_tag[NCH];
  string rd_tag;

  function automatic int chb(int c);
    return 'h200 + c * 'h20;
  endfunction

  task automatic check(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int read_model(int a);
    int v = 0;
    if (a == 'h004) for (int c = 0; c < NCH; c++) v |= int'(m_en[c]) << c;
    if (a == 'h010) for (int c = 0; c < NCH; c++) v |= int'(m_mask[c]) << c;
    if (a == 'h01C) for (int c = 0; c < NCH; c++) v |= int'(m_stat[c]) << c;
    for (int c = 0; c < NCH; c++) begin
      if (a == chb(c) + 'h0) v = m_per[c];
      if (a == chb(c) + 'h4) v = m_perp[c];
      if (a == chb(c) + 'h8) v = m_duty[c];
      if (a == chb(c) + 'hC) v = m_dutyp[c];
    end
    return v;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_per[c] = 0; m_perp[c] = 0; m_duty[c] = 0; m_dutyp[c] = 0; m_cnt[c] = 0;
      m_en[c] = 0; m_mask[c] = 0; m_stat[c] = 0; m_pwm[c] = 0;
    end
    m_irq = 0; m_rdata = 0;
  endtask

  task automatic model_step(bit w, bit r, int a, int d);
    bit wrapv[NCH];
    bit any = 0;
    for (int c = 0; c < NCH; c++) any |= m_stat[c] & m_mask[c];
    m_irq = any;
    m_rdata = r ? read_model(a) : 0;
    if (r) begin
      if (a == 'h01C) begin
        rd_tag = "R7";
        for (int c = 0; c < NCH; c++) if (m_en[c] && m_cnt[c] + 1 >= m_per[c]) rd_tag = "R7 set-during-read";
        if (rd_tag == "R7") rd_tag = "R6";
      end else if (a == 'h004 || a == 'h010) rd_tag = "R9";
      else if (a >= 'h200 && a < 'h280) rd_tag = ((a & 'h4) != 0) ? "R2" : "R3";
      else rd_tag = "R1";
    end else rd_tag = "R1";
    for (int c = 0; c < NCH; c++) begin
      if (!m_en[c]) pwm_tag[c] = "R9";
      else if (m_duty[c] == 0 || m_duty[c] >= m_per[c]) pwm_tag[c] = "R5";
      else pwm_tag[c] = "R4";
      if (after_reset) pwm_tag[c] = "R10";
      m_pwm[c] = m_en[c] && (m_cnt[c] < m_duty[c]);
      wrapv[c] = m_en[c] && (m_cnt[c] + 1 >= m_per[c]);
    end
    for (int c = 0; c < NCH; c++) begin
      if (r && a == 'h01C) m_stat[c] = 0;
      if (wrapv[c]) m_stat[c] = 1;
      if (!m_en[c] || wrapv[c]) begin
        m_per[c] = m_perp[c]; m_duty[c] = m_dutyp[c]; m_cnt[c] = 0;
      end else m_cnt[c]++;
    end
    if (w) begin
      for (int c = 0; c < NCH; c++) begin
        if (a == chb(c) + 'h4) m_perp[c]  = d & CMAX;
        if (a == chb(c) + 'hC) m_dutyp[c] = d & CMAX;
        if (a == 'h004 && d[c]) m_en[c] = 1;
        if (a == 'h008 && d[c]) m_en[c] = 0;
        if (a == 'h010) m_mask[c] = d[c];
      end
    end
  endtask

  task automatic cyc(bit w, bit r, int a, int d);
    bus_wr = w; bus_rd = r; bus_addr = a[11:0]; bus_wdata = d;
    @(posedge clk);
    model_step(w, r, a, d);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) check({pwm_tag[c], " pwm_out"}, int'(pwm_out[c]), int'(m_pwm[c]));
    check(after_reset ? "R10 irq" : "R8 irq", int'(irq), int'(m_irq));
    check(after_reset ? "R10 rdata" : {rd_tag, " rdata"}, int'(bus_rdata), m_rdata);
  endtask

  task automatic wr(int a, int d); cyc(1, 0, a, d); endtask
  task automatic rd(int a);        cyc(0, 1, a, 0); endtask
  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0);
  endtask
  task automatic poll(int n, int gap);
    for (int k = 0; k < n; k++) begin
      idle(gap);
      rd('h01C);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    after_reset = 1'b1;
    idle(2);
    rd('h01C);
    after_reset = 1'b0;
    rd('h004); rd('h010); rd('h300); rd('h0F0); rd(chb(0));
    // R1 writes to unmapped addresses are ignored
    wr('h0F0, 'hFF); wr('h284, 'h55); rd(chb(0) + 4); rd('h004);
    // program pending values while disabled (R9 immediate load)
    wr(chb(0) + 'h4, 10); wr(chb(0) + 'hC, 3);
    wr(chb(1) + 'h4, 6);  wr(chb(1) + 'hC, 0);
    wr(chb(2) + 'h4, 5);  wr(chb(2) + 'hC, 7);
    wr(chb(3) + 'h4, 1);  wr(chb(3) + 'hC, 1);
    rd(chb(0)); rd(chb(2) + 8); rd(chb(3) + 'hC);
    wr('h010, 'h1);
    wr('h004, 'hF);
    rd('h004);
    idle(25);
    poll(10, 6);
    // R2 R3 mid-period write to enabled channel
    wr(chb(0) + 'hC, 8); wr(chb(0) + 'h4, 12);
    rd(chb(0) + 8); rd(chb(0) + 'hC); rd(chb(0));
    idle(15);
    rd(chb(0)); rd(chb(0) + 8);
    // R9 disable one channel
    wr('h008, 'h2); rd('h004);
    idle(10);
    wr(chb(1) + 'hC, 4);
    rd(chb(1) + 8);
    wr('h004, 'h2);
    idle(20);
    // R5 duty to zero, full mask, collide reads with wraps
    wr(chb(2) + 'hC, 0);
    wr('h010, 'hF);
    poll(20, 3);
    // period 0 and duty above period on channel 3
    wr(chb(3) + 'h4, 0); wr(chb(3) + 'hC, 0);
    idle(6);
    wr(chb(3) + 'h4, 200); wr(chb(3) + 'hC, 255);
    idle(10);
    poll(8, 1);
    wr('h010, 'h0);
    idle(4);
    wr('h008, 'hF);
    idle(4);
    rd('h01C); rd('h01C);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule